// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

This block is a one-way FIFO. Port A writes 36-bit words into a storage array. Port B reads them back on its own free-running clock. Port B can be set up as a 36-, 18- or 9-bit reader. In the narrow settings each stored word leaves as two or four pieces, and a selectable endian order decides which half or byte comes out first. A word stays in the array, and keeps counting against its capacity, until its last piece has been read.

Port B has two timing modes.

- **Standard mode:** `b_avail` means "at least one whole word is stored". A piece moves to `b_dout` on the clock edge that accepts a read.
- **Fall-through mode:** `b_avail` means "`b_dout` already holds a valid piece". The first piece appears without any read request, and each read advances to the next piece.

The two pointers cross between the clock domains as Gray codes through two-flop synchronizers. Because of this, `a_room` and `b_avail` are conservative: they can lag by a few cycles, but they never report space or data that is not there.

The read controller has three named states:

| State | Meaning |
|---|---|
| `RD_STD` | Standard mode. The controller stays here and loads one piece per accepted read. |
| `RD_FW_WAIT` | Fall-through mode, output empty. |
| `RD_FW_SHOW` | Fall-through mode, output valid. |

Its transitions are:

| Transition | From → To | Condition |
|---|---|---|
| FILL | `RD_FW_WAIT` → `RD_FW_SHOW` | A whole word is stored. |
| NEXT | `RD_FW_SHOW` → `RD_FW_SHOW` | A read with another piece or word still available. |
| DRAIN | `RD_FW_SHOW` → `RD_FW_WAIT` | A read of the last piece of the last stored word. |
| HOLD | any state → itself | No qualifying event. |

Reset places the controller in `RD_STD` or `RD_FW_WAIT`, according to the mode.

**Resets.**

- Full reset (`rst_n` low) clears the contents and samples the configuration inputs.
- Partial reset (`prst_n` low) clears the contents but keeps the configuration that was already latched.
- Both resets are synchronous. Each must be held for several edges of both clocks.

Top module: `bmf_fifo`

## Requirements
- R1: After a full reset the block shows `a_room`=1, `b_avail`=0 and `b_dout`=0.
- R2: Words come out of port B in the order they were written, with none lost or repeated. This holds while both ports run at the same time on unrelated clocks.
- R3: The bus width follows `cfg_width`. The value 00 (or 11) selects 36 bits and one piece per word. The value 01 selects 18 bits and two pieces. The value 10 selects 9 bits and four pieces. A narrow piece sits in the low bits of `b_dout`, and all bits above it are zero.
- R4: With `cfg_big`=1 the first piece of a word is its most significant half or byte. With `cfg_big`=0 the first piece is the least significant one.
- R5: In standard mode (`cfg_fwft`=0), `b_avail` is high while a whole word is stored. `b_dout` changes only on the `clk_b` edge that accepts a read, and then shows the next piece.
- R6: In fall-through mode (`cfg_fwft`=1), the first piece appears on `b_dout` with `b_avail`=1 and no read request. While `b_avail`=1 and `b_rd`=0, `b_dout` holds.
- R7: `a_room` goes low once DEPTH words are stored. A write while `a_room`=0 is dropped and is never read out.
- R8: In standard mode, a read while `b_avail`=0 leaves `b_dout` and the read position unchanged. The next word written is the next one read.
- R9: A word frees its slot only after its last piece has been read. With the array full in 9-bit mode, `a_room` stays 0 after three pieces and returns to 1 after the fourth.
- R10: A partial reset discards all stored words and gives `a_room`=1 and `b_avail`=0. The latched width, endian and mode settings stay unchanged.
- R11: The configuration inputs are sampled only while `rst_n` is low. Changing them at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low: clears contents and samples configuration |
| prst_n | input | 1 | Partial reset, active low: clears contents, keeps configuration |
| cfg_width | input | 2 | Read bus width select: 00=36, 01=18, 10=9 bits |
| cfg_big | input | 1 | 1 = most significant piece first |
| cfg_fwft | input | 1 | 1 = fall-through timing, 0 = standard timing |
| a_wr | input | 1 | Write request |
| a_din | input | DW | Write data |
| a_room | output | 1 | Space for at least one word |
| b_rd | input | 1 | Read request |
| b_dout | output | DW | Read data, narrow pieces in the low bits |
| b_avail | output | 1 | Standard: a word is stored; fall-through: `b_dout` is valid |

## Verification
The hardest case to reach is a full array whose head word has been partly read in a narrow mode. The slot must stay occupied until the final piece has gone, and only the port A flag can show this. The bench fills a 16-word instance in 9-bit mode and reads three pieces. It waits long enough for the read pointer to cross into the `clk_a` domain, checks that `a_room` is still low, then reads the fourth piece and checks that space comes back. It also sweeps every width, endian and timing combination with a writer and reader running concurrently on unrelated clocks, so the full flag is hit in the middle of reads.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    typedef enum logic [1:0] {
        BW_LONG = 2'b00,
        BW_WORD = 2'b01,
        BW_BYTE = 2'b10
    } bus_w_e;

    typedef enum logic [1:0] {
        RD_STD     = 2'b00,
        RD_FW_WAIT = 2'b01,
        RD_FW_SHOW = 2'b10
    } rd_state_e;

endpackage

// File: rtl/bmf_sync.sv
module bmf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bmf_mem.sv
module bmf_mem #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [1<<AW];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/bmf_wr_ctl.sv
module bmf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wr,
    input  logic [AW:0]   rgray_s,
    output logic          full,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray
);
    logic [AW:0] bin_n;

    // Full: the write pointer has lapped the read pointer by one whole array.
    assign full  = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign we    = wr && !full;
    assign bin_n = wbin + 1'b1;
    assign waddr = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (clr) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= bin_n;
            wgray <= bin_n ^ (bin_n >> 1);
        end
    end
endmodule

// File: rtl/bmf_rd_ctl.sv
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          cfg_load,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_big,
    input  logic          cfg_fwft,
    input  logic          rd,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          avail,
    output logic          fwft_q,
    output logic [3:0]    cfg_snap
);
    localparam int HW = DW / 2;
    localparam int QW = DW / 4;

    bus_w_e    busw_q;
    logic      big_q;
    rd_state_e state_q, state_d;
    logic [AW:0] bin_q, nxt_bin, nxt_gray;
    logic [1:0]  pc_q, nxt_pc, last_pc, sel_pc;
    logic        empty, nxt_empty, take, adv, load;
    logic [DW-1:0] piece;

    // Configuration is sampled only while the full reset is held.
    always_ff @(posedge clk) begin
        if (cfg_load) begin
            busw_q <= (cfg_width == 2'b01) ? BW_WORD :
                      (cfg_width == 2'b10) ? BW_BYTE : BW_LONG;
            big_q  <= cfg_big;
            fwft_q <= cfg_fwft;
        end
    end
    assign cfg_snap = {busw_q, big_q, fwft_q};

    always_comb begin
        unique case (busw_q)
            BW_WORD: last_pc = 2'd1;
            BW_BYTE: last_pc = 2'd3;
            default: last_pc = 2'd0;
        endcase
    end

    // Whole-word occupancy and the position after the current piece.
    assign empty     = (rgray == wgray_s);
    assign nxt_bin   = (pc_q == last_pc) ? bin_q + 1'b1 : bin_q;
    assign nxt_pc    = (pc_q == last_pc) ? 2'd0 : pc_q + 2'd1;
    assign nxt_gray  = nxt_bin ^ (nxt_bin >> 1);
    assign nxt_empty = (nxt_gray == wgray_s);
    assign avail     = fwft_q ? (state_q == RD_FW_SHOW) : !empty;
    assign take      = rd && avail;

    assign raddr  = (state_q == RD_FW_SHOW) ? nxt_bin[AW-1:0] : bin_q[AW-1:0];
    assign sel_pc = (state_q == RD_FW_SHOW) ? nxt_pc : pc_q;

    // Piece extraction with endian ordering, zero-extended into the bus.
    always_comb begin
        logic [1:0] slot;
        slot  = big_q ? (2'd3 - sel_pc) : sel_pc;
        piece = rdata;
        unique case (busw_q)
            BW_WORD: piece = {{(DW-HW){1'b0}},
                              ((sel_pc[0] ^ big_q) ? rdata[DW-1:HW] : rdata[HW-1:0])};
            BW_BYTE: piece = {{(DW-QW){1'b0}}, rdata[slot*QW +: QW]};
            default: piece = rdata;
        endcase
    end

    // Next-state and control decisions.
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            RD_STD: begin
                adv  = take;
                load = take;
            end
            RD_FW_WAIT: begin
                if (!empty) begin
                    state_d = RD_FW_SHOW;
                    load    = 1'b1;
                end
            end
            RD_FW_SHOW: begin
                if (rd) begin
                    adv = 1'b1;
                    if (pc_q != last_pc || !nxt_empty) load    = 1'b1;
                    else                               state_d = RD_FW_WAIT;
                end
            end
            default: state_d = RD_STD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (clr) state_q <= (cfg_load ? cfg_fwft : fwft_q) ? RD_FW_WAIT : RD_STD;
        else     state_q <= state_d;
    end

    // Pointer, piece counter and output register.
    always_ff @(posedge clk) begin
        if (clr) begin
            bin_q <= '0;
            rgray <= '0;
            pc_q  <= '0;
            dout  <= '0;
        end else begin
            if (adv) begin
                bin_q <= nxt_bin;
                rgray <= nxt_gray;
                pc_q  <= nxt_pc;
            end
            if (load) dout <= piece;
        end
    end
endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo #(
    parameter int DW    = 36,
    parameter int DEPTH = 256
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_big,
    input  logic          cfg_fwft,
    input  logic          a_wr,
    input  logic [DW-1:0] a_din,
    output logic          a_room,
    input  logic          b_rd,
    output logic [DW-1:0] b_dout,
    output logic          b_avail
);
    localparam int AW = $clog2(DEPTH);

    logic          clr;
    logic          full, we;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wr_bin, wr_gray, rd_gray, wr_gray_b, rd_gray_a;
    logic [DW-1:0] rdata;
    logic          fwft_q;
    logic [3:0]    cfg_snap;

    assign clr    = !rst_n || !prst_n;
    assign a_room = !full;

    bmf_wr_ctl #(.AW(AW)) u_wr (
        .clk(clk_a), .clr(clr), .wr(a_wr), .rgray_s(rd_gray_a),
        .full(full), .we(we), .waddr(waddr), .wbin(wr_bin), .wgray(wr_gray)
    );

    bmf_sync #(.W(AW+1)) u_sync_w2r (
        .clk(clk_b), .clr(clr), .d(wr_gray), .q(wr_gray_b)
    );

    bmf_sync #(.W(AW+1)) u_sync_r2w (
        .clk(clk_a), .clr(clr), .d(rd_gray), .q(rd_gray_a)
    );

    bmf_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk_a), .we(we), .waddr(waddr), .wdata(a_din),
        .raddr(raddr), .rdata(rdata)
    );

    bmf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .clk(clk_b), .clr(clr), .cfg_load(!rst_n),
        .cfg_width(cfg_width), .cfg_big(cfg_big), .cfg_fwft(cfg_fwft),
        .rd(b_rd), .wgray_s(wr_gray_b), .rdata(rdata),
        .raddr(raddr), .rgray(rd_gray), .dout(b_dout), .avail(b_avail),
        .fwft_q(fwft_q), .cfg_snap(cfg_snap)
    );
endmodule

// File: rtl/bmf_chk.sv
module bmf_chk #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic          prst_n,
    input logic          a_wr,
    input logic          a_room,
    input logic [AW:0]   wr_bin,
    input logic          b_rd,
    input logic          b_avail,
    input logic [DW-1:0] b_dout,
    input logic          fwft_q,
    input logic [3:0]    cfg_snap
);
    // R1
    reset_idle_chk: assert property (@(posedge clk_b)
        !rst_n |=> (!b_avail && b_dout == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk_a) disable iff (!rst_n || !prst_n)
        (a_wr && !a_room) |=> (wr_bin == $past(wr_bin)));

    // R8
    empty_read_chk: assert property (@(posedge clk_b) disable iff (!rst_n || !prst_n)
        (!fwft_q && b_rd && !b_avail) |=> $stable(b_dout));

    // R6
    fwft_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n || !prst_n)
        (fwft_q && b_avail && !b_rd) |=> (b_avail && $stable(b_dout)));

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk_b) disable iff (!rst_n || !prst_n)
        ((cfg_snap[3:2] == 2'b10) |-> (b_dout[DW-1:DW/4] == '0)) and
        ((cfg_snap[3:2] == 2'b01) |-> (b_dout[DW-1:DW/2] == '0)));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_snap));
endmodule

bind bmf_fifo bmf_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .prst_n(prst_n),
    .a_wr(a_wr), .a_room(a_room), .wr_bin(wr_bin),
    .b_rd(b_rd), .b_avail(b_avail), .b_dout(b_dout),
    .fwft_q(fwft_q), .cfg_snap(cfg_snap)
);

// File: tb/tb_bmf_fifo.sv
module tb_bmf_fifo;
    localparam int DW    = 36;
    localparam int DEPTH = 16;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_n = 1'b0, prst_n = 1'b1;
    logic [1:0] cfg_width = 2'b00;
    logic cfg_big = 1'b0, cfg_fwft = 1'b0;
    logic a_wr = 1'b0, b_rd = 1'b0;
    logic [DW-1:0] a_din = '0;
    logic a_room, b_avail;
    logic [DW-1:0] b_dout;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    bmf_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .prst_n(prst_n),
        .cfg_width(cfg_width), .cfg_big(cfg_big), .cfg_fwft(cfg_fwft),
        .a_wr(a_wr), .a_din(a_din), .a_room(a_room),
        .b_rd(b_rd), .b_dout(b_dout), .b_avail(b_avail)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int pieces(input logic [1:0] w);
        return (w == 2'b01) ? 2 : (w == 2'b10) ? 4 : 1;
    endfunction

    function automatic logic [DW-1:0] exp_piece(input logic [DW-1:0] w, input int np, input bit big, input int idx);
        int pw, slot;
        logic [DW-1:0] m;
        pw   = DW / np;
        slot = big ? (np - 1 - idx) : idx;
        m    = (pw == DW) ? '1 : ((DW'(1) << pw) - DW'(1));
        return (w >> (slot * pw)) & m;
    endfunction

    function automatic logic [DW-1:0] pat(input int k, input int tag);
        return 36'h9A5C30F1E ^ (DW'(k) * 36'h102030405) ^ (DW'(tag) << 29);
    endfunction

    task automatic do_reset(input logic [1:0] w, input bit big, input bit fw);
        a_wr = 1'b0; b_rd = 1'b0;
        cfg_width = w; cfg_big = big; cfg_fwft = fw;
        rst_n = 1'b0;
        repeat (4) @(negedge clk_b);
        repeat (2) @(negedge clk_a);
        rst_n = 1'b1;
        // R11: scramble configuration inputs after release
        cfg_width = (w == 2'b10) ? 2'b00 : 2'b10;
        cfg_big   = ~big;
        cfg_fwft  = ~fw;
    endtask

    task automatic write_word(input logic [DW-1:0] w);
        @(negedge clk_a);
        while (!a_room) @(negedge clk_a);
        a_wr = 1'b1; a_din = w;
        @(negedge clk_a);
        a_wr = 1'b0;
    endtask

    task automatic read_piece(input bit fw, output logic [DW-1:0] p);
        @(negedge clk_b);
        while (!b_avail) @(negedge clk_b);
        if (fw) begin
            p = b_dout; b_rd = 1'b1;
            @(negedge clk_b);
            b_rd = 1'b0;
        end else begin
            b_rd = 1'b1;
            @(negedge clk_b);
            b_rd = 1'b0; p = b_dout;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] p, d;

        // Sweep: every width, endian and timing mode, concurrent ports (R2 R3 R4 R5 R6 R11)
        for (int w = 0; w < 3; w++) begin
            for (int big = 0; big < 2; big++) begin
                for (int fw = 0; fw < 2; fw++) begin
                    int tag, np;
                    tag = w * 4 + big * 2 + fw;
                    np  = pieces(2'(w));
                    do_reset(2'(w), big[0], fw[0]);
                    // R1
                    chk(a_room == 1'b1 && b_avail == 1'b0 && b_dout == '0, "R1 reset state",
                        {a_room, b_avail, b_dout[DW-3:0]}, {1'b1, 1'b0, 34'h0});
                    fork
                        begin
                            for (int k = 0; k < 20; k++) write_word(pat(k, tag));
                        end
                        begin
                            for (int k = 0; k < 20; k++) begin
                                for (int i = 0; i < np; i++) begin
                                    logic [DW-1:0] q;
                                    read_piece(fw[0], q);
                                    chk(q == exp_piece(pat(k, tag), np, big[0], i),
                                        fw ? "R2 R3 R4 R6 R11 sweep" : "R2 R3 R4 R5 R11 sweep",
                                        q, exp_piece(pat(k, tag), np, big[0], i));
                                end
                            end
                        end
                    join
                end
            end
        end

        // R7: fill, dropped write, then drain
        do_reset(2'b00, 1'b0, 1'b0);
        for (int k = 0; k < DEPTH; k++) write_word(pat(k, 40));
        repeat (2) @(negedge clk_a);
        chk(a_room == 1'b0, "R7 full flag", DW'(a_room), DW'(0));
        a_wr = 1'b1; a_din = 36'hDEADBEEF5;
        @(negedge clk_a);
        a_wr = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            read_piece(1'b0, p);
            chk(p == pat(k, 40), "R7 contents after dropped write", p, pat(k, 40));
        end
        repeat (10) @(negedge clk_b);
        chk(b_avail == 1'b0, "R7 dropped word absent", DW'(b_avail), DW'(0));

        // R8: read while empty in standard mode
        d = b_dout;
        b_rd = 1'b1;
        @(negedge clk_b);
        b_rd = 1'b0;
        chk(b_dout == d, "R8 output unchanged", b_dout, d);
        write_word(pat(7, 41));
        repeat (10) @(negedge clk_b);
        // R5: data waits for a read request in standard mode
        chk(b_avail == 1'b1 && b_dout == d, "R5 no output before read", b_dout, d);
        read_piece(1'b0, p);
        chk(p == pat(7, 41), "R8 read position kept", p, pat(7, 41));

        // R9: partly read head word keeps its slot
        do_reset(2'b10, 1'b1, 1'b0);
        for (int k = 0; k < DEPTH; k++) write_word(pat(k, 42));
        for (int i = 0; i < 3; i++) begin
            read_piece(1'b0, p);
            chk(p == exp_piece(pat(0, 42), 4, 1'b1, i), "R9 piece", p, exp_piece(pat(0, 42), 4, 1'b1, i));
        end
        repeat (8) @(negedge clk_a);
        chk(a_room == 1'b0, "R9 slot held after three pieces", DW'(a_room), DW'(0));
        read_piece(1'b0, p);
        chk(p == exp_piece(pat(0, 42), 4, 1'b1, 3), "R9 last piece", p, exp_piece(pat(0, 42), 4, 1'b1, 3));
        repeat (8) @(negedge clk_a);
        chk(a_room == 1'b1, "R9 slot freed after last piece", DW'(a_room), DW'(1));

        // R10: partial reset keeps 9-bit little-endian fall-through setting
        do_reset(2'b10, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) write_word(pat(k, 43));
        repeat (10) @(negedge clk_b);
        cfg_width = 2'b00; cfg_big = 1'b1; cfg_fwft = 1'b0;
        prst_n = 1'b0;
        repeat (4) @(negedge clk_b);
        repeat (2) @(negedge clk_a);
        prst_n = 1'b1;
        chk(b_avail == 1'b0 && a_room == 1'b1, "R10 cleared by partial reset",
            {b_avail, a_room}, {1'b0, 1'b1});
        write_word(pat(9, 43));
        repeat (10) @(negedge clk_b);
        // R6: first piece presented without a read
        chk(b_avail == 1'b1 && b_dout == exp_piece(pat(9, 43), 4, 1'b0, 0), "R6 fall-through first piece",
            b_dout, exp_piece(pat(9, 43), 4, 1'b0, 0));
        for (int i = 0; i < 4; i++) begin
            read_piece(1'b1, p);
            chk(p == exp_piece(pat(9, 43), 4, 1'b0, i), "R10 configuration kept", p, exp_piece(pat(9, 43), 4, 1'b0, i));
        end
        repeat (10) @(negedge clk_b);
        chk(b_avail == 1'b0, "R10 old words discarded", DW'(b_avail), DW'(0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule